// File: doc/BRIEF.md
# FP32 Multiply-by-Immediate Execution Unit

This unit executes one instruction of a small floating-point register file with eight single-precision registers. The instruction multiplies a source register by a constant held in the instruction word. The constant is only sixteen bits wide and stands for the upper half of a single-precision number. The lower sixteen mantissa bits of that number are taken as zero. The unit decodes the 32-bit instruction word and reads the source register through a combinational read port. It rounds the product and returns the result on a write-back port two cycles after issue, tagged with its destination index.

The register file outside the block writes at the end of the write-back cycle and forwards the written value to a read in that same cycle. An instruction issued one cycle after a multiply (the delay slot) therefore still sees the old destination value. An instruction issued two cycles after it sees the new value. Two sticky status bits record overflow and underflow. They stay set until a clear pulse. No other status is produced.

The arithmetic is a reduced single-precision model. Zero and denormal inputs count as zero. Results below the normal range flush to signed zero. Results above it saturate to signed infinity. An exponent field of all ones carries no special meaning.

Top module: `fmuli_unit`

## Requirements
- R1: An instruction is accepted only when `issue_valid` is high and bits 15:6 of `issue_word` equal 10'b1110100001. Any other word, or a word presented with `issue_valid` low, produces no write-back and leaves both flags unchanged.
- R2: Field positions are fixed. The 16-bit immediate is {issue_word[5:0], issue_word[31:22]}, the source index is issue_word[21:19] and the destination index is issue_word[18:16]. During the issue cycle `rf_rd_idx` equals the source index.
- R3: The immediate forms bits 31:16 of the second operand, and bits 15:0 of that operand are zero. For example, 1.0 times immediate 0x3FAB gives exactly 0x3FAB0000.
- R4: For normal operands the result is the product rounded to nearest, ties to even. For example, 0x40000000 times immediate 0x4040 gives 0x40C00000, and immediate 0xBFC0 acts as -1.5.
- R5: An instruction issued in cycle T raises `wb_valid` in cycle T+2, with `wb_idx` equal to its destination index. Instructions may issue in every cycle, and each produces exactly one write-back, in issue order.
- R6: If either operand has a zero exponent field (zero or denormal), the result is a zero whose sign is the XOR of the operand signs, and no flag is raised.
- R7: If the rounded biased exponent is 255 or more, the result is signed infinity (exponent 0xFF, mantissa zero) and `ovf_flag` is set in the write-back cycle.
- R8: If the rounded biased exponent is 0 or less, with both operands nonzero, the result is signed zero and `unf_flag` is set in the write-back cycle.
- R9: Both flags are sticky. A `flag_clr` pulse in cycle C clears them in cycle C+1, unless an overflow or underflow write-back falls in cycle C+1; in that case the affected flag reads set.
- R10: While `rst_n` is low, and in the first cycle after it, `wb_valid`, `ovf_flag` and `unf_flag` are low.
- R11: An operand exponent field of 0xFF is handled as an ordinary exponent. Infinity times 0.5 gives 0x7F000000, and infinity times 1.0 overflows to infinity. No result is ever a NaN pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | Instruction word present this cycle |
| issue_word | input | 32 | Instruction, high half-word in bits 31:16 |
| rf_rd_idx | output | 3 | Register-file read index (source) |
| rf_rd_data | input | 32 | Register-file read data for `rf_rd_idx` |
| wb_valid | output | 1 | Write-back strobe |
| wb_idx | output | 3 | Write-back destination index |
| wb_data | output | 32 | Write-back value |
| flag_clr | input | 1 | Clears both sticky flags |
| ovf_flag | output | 1 | Sticky overflow flag |
| unf_flag | output | 1 | Sticky underflow flag |

## Verification
A flag clear and a flag-raising write-back can reach the flag register at the same clock edge. The bench provokes this by pulsing `flag_clr` in the delay slot of an overflowing multiply, and also with random clear pulses during a random instruction stream. It judges the result against a reference flag model, which holds the previous value, applies the clear and then ORs in the event of the current write-back. A second pairing is a register write-back and a read of the same register in one cycle. Dependent issues one and two cycles after a producer check that the delay slot sees the old value and the next slot sees the new one.

// File: rtl/fmuli_pkg.sv
// Package: shared widths, field constants and the stage-1 record of the
// multiply-by-immediate unit. Assumes IEEE single-precision field layout.
package fmuli_pkg;
    localparam int WORD_W     = 32;
    localparam int EXP_W      = 8;
    localparam int MAN_W      = 23;
    localparam int IMM_W      = 16;
    localparam int NUM_REGS   = 8;
    localparam int IDX_W      = $clog2(NUM_REGS);
    localparam int EXP_BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_TOP    = (1 << EXP_W) - 1;
    // mantissa bits carried by the immediate (the rest are zero)
    localparam int IMM_MAN_W  = MAN_W - (WORD_W - IMM_W);
    // significand product width: (hidden+MAN_W) x (hidden+IMM_MAN_W)
    localparam int PROD_W     = (MAN_W + 1) + (IMM_MAN_W + 1);
    // signed exponent width with headroom for sum and carries
    localparam int XW         = EXP_W + 2;
    localparam int OPC_W      = 10;
    localparam logic [OPC_W-1:0] OPC_CODE = 10'b1110100001;

    typedef struct packed {
        logic                     sign;
        logic                     zero;
        logic signed [XW-1:0]     exp_sum;
        logic [PROD_W-1:0]        prod;
        logic [IDX_W-1:0]         dst;
    } mul_rec_t;
endpackage

// File: rtl/fmuli_decode.sv
// Module: fmuli_decode
// Decodes the two half-words of the instruction into opcode hit, source and
// destination indices and the 16-bit immediate. Purely combinational.
// Assumes the high half-word sits in bits 31:16 of the word.
module fmuli_decode
    import fmuli_pkg::*;
(
    input  logic                 issue_valid,
    input  logic [WORD_W-1:0]    issue_word,
    output logic                 hit,
    output logic [IDX_W-1:0]     src_idx,
    output logic [IDX_W-1:0]     dst_idx,
    output logic [IMM_W-1:0]     imm
);
    localparam int HALF = WORD_W / 2;
    localparam int LO_IMM_W = HALF - OPC_W;

    logic [HALF-1:0] lo_hw;
    logic [HALF-1:0] hi_hw;

    // split into half-words and pick out the fields
    always_comb begin
        lo_hw   = issue_word[HALF-1:0];
        hi_hw   = issue_word[WORD_W-1:HALF];
        hit     = issue_valid && (lo_hw[HALF-1 -: OPC_W] == OPC_CODE);
        dst_idx = hi_hw[IDX_W-1:0];
        src_idx = hi_hw[2*IDX_W-1:IDX_W];
        imm     = {lo_hw[LO_IMM_W-1:0], hi_hw[HALF-1:2*IDX_W]};
    end
endmodule

// File: rtl/fmuli_mul_stage.sv
// Module: fmuli_mul_stage
// Stage 1: unpacks the register operand and the immediate, forms sign,
// zero-operand flag, exponent sum and the narrow significand product, and
// registers them. The immediate's low operand bits are zero by definition, so
// only its upper mantissa bits enter the multiplier.
module fmuli_mul_stage
    import fmuli_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [WORD_W-1:0]    op_reg,
    input  logic [IMM_W-1:0]     op_imm,
    input  logic [IDX_W-1:0]     in_dst,
    output logic                 s1_valid,
    output mul_rec_t             s1_rec
);
    logic [EXP_W-1:0]      exp_a;
    logic [EXP_W-1:0]      exp_b;
    logic [MAN_W:0]        sig_a;
    logic [IMM_MAN_W:0]    sig_b;
    mul_rec_t              rec_c;

    // unpack both operands and build the stage-1 record
    always_comb begin
        exp_a         = op_reg[WORD_W-2 -: EXP_W];
        exp_b         = op_imm[IMM_W-2 -: EXP_W];
        sig_a         = {1'b1, op_reg[MAN_W-1:0]};
        sig_b         = {1'b1, op_imm[IMM_MAN_W-1:0]};
        rec_c.sign    = op_reg[WORD_W-1] ^ op_imm[IMM_W-1];
        rec_c.zero    = (exp_a == '0) || (exp_b == '0);
        rec_c.exp_sum = $signed(XW'(exp_a)) + $signed(XW'(exp_b))
                        - $signed(XW'(EXP_BIAS));
        rec_c.prod    = PROD_W'(sig_a) * PROD_W'(sig_b);
        rec_c.dst     = in_dst;
    end

    // pipeline register for stage 1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_rec   <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_rec   <= rec_c;
        end
    end
endmodule

// File: rtl/fmuli_round_stage.sv
// Module: fmuli_round_stage
// Stage 2: normalises the product, rounds to nearest-even, applies flush to
// zero and saturation to infinity, and registers the write-back. Overflow and
// underflow events are given out combinationally so the flag unit updates at
// the same edge as the write-back register.
module fmuli_round_stage
    import fmuli_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s1_valid,
    input  mul_rec_t             s1_rec,
    output logic                 ovf_evt,
    output logic                 unf_evt,
    output logic                 wb_valid,
    output logic [IDX_W-1:0]     wb_idx,
    output logic [WORD_W-1:0]    wb_data
);
    logic                  norm;
    logic [PROD_W-2:0]     aligned;
    logic [MAN_W-1:0]      man_keep;
    logic                  guard;
    logic                  sticky;
    logic                  rnd_up;
    logic [MAN_W:0]        man_rnd;
    logic signed [XW-1:0]  exp_fin;
    logic [WORD_W-1:0]     res_c;

    // normalise, round and classify the result
    always_comb begin
        norm     = s1_rec.prod[PROD_W-1];
        aligned  = norm ? s1_rec.prod[PROD_W-2:0]
                        : {s1_rec.prod[PROD_W-3:0], 1'b0};
        man_keep = aligned[PROD_W-2 -: MAN_W];
        guard    = aligned[PROD_W-2-MAN_W];
        sticky   = |aligned[PROD_W-3-MAN_W:0];
        rnd_up   = guard && (sticky || man_keep[0]);
        man_rnd  = {1'b0, man_keep} + (MAN_W+1)'(rnd_up);
        exp_fin  = s1_rec.exp_sum + $signed(XW'(norm)) + $signed(XW'(man_rnd[MAN_W]));
        ovf_evt  = s1_valid && !s1_rec.zero && (exp_fin >= $signed(XW'(EXP_TOP)));
        unf_evt  = s1_valid && !s1_rec.zero && (exp_fin <= $signed(XW'(0)));
        if (s1_rec.zero || (exp_fin <= $signed(XW'(0)))) begin
            res_c = {s1_rec.sign, {(WORD_W-1){1'b0}}};
        end else if (exp_fin >= $signed(XW'(EXP_TOP))) begin
            res_c = {s1_rec.sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
        end else begin
            res_c = {s1_rec.sign, exp_fin[EXP_W-1:0], man_rnd[MAN_W-1:0]};
        end
    end

    // write-back register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_idx   <= '0;
            wb_data  <= '0;
        end else begin
            wb_valid <= s1_valid;
            wb_idx   <= s1_rec.dst;
            wb_data  <= res_c;
        end
    end
endmodule

// File: rtl/fmuli_flags.sv
// Module: fmuli_flags
// A row of sticky status bits. Each bit sets on its event, clears on the
// shared clear input, and a set beats a clear at the same edge.
module fmuli_flags #(
    parameter int N_FLAGS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_FLAGS-1:0]   set_in,
    input  logic                 clr_in,
    output logic [N_FLAGS-1:0]   flag_out
);
    for (genvar i = 0; i < N_FLAGS; i++) begin : g_bit
        logic q;
        // hold, set or clear one sticky bit
        always_ff @(posedge clk) begin
            if (!rst_n)          q <= 1'b0;
            else if (set_in[i])  q <= 1'b1;
            else if (clr_in)     q <= 1'b0;
        end
        assign flag_out[i] = q;
    end
endmodule

// File: rtl/fmuli_unit.sv
// Module: fmuli_unit (top)
// Two-cycle single-precision multiply of a register by an instruction
// immediate with sticky overflow/underflow flags. Assumes the external
// register file reads combinationally and forwards a same-cycle write.
module fmuli_unit
    import fmuli_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue_valid,
    input  logic [WORD_W-1:0]    issue_word,
    output logic [IDX_W-1:0]     rf_rd_idx,
    input  logic [WORD_W-1:0]    rf_rd_data,
    output logic                 wb_valid,
    output logic [IDX_W-1:0]     wb_idx,
    output logic [WORD_W-1:0]    wb_data,
    input  logic                 flag_clr,
    output logic                 ovf_flag,
    output logic                 unf_flag
);
    logic              dec_hit;
    logic [IDX_W-1:0]  dec_src;
    logic [IDX_W-1:0]  dec_dst;
    logic [IMM_W-1:0]  dec_imm;
    logic              s1_valid;
    mul_rec_t          s1_rec;
    logic              ovf_evt;
    logic              unf_evt;
    logic [1:0]        flags;

    fmuli_decode u_dec (
        .issue_valid (issue_valid),
        .issue_word  (issue_word),
        .hit         (dec_hit),
        .src_idx     (dec_src),
        .dst_idx     (dec_dst),
        .imm         (dec_imm)
    );

    assign rf_rd_idx = dec_src;

    fmuli_mul_stage u_mul (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (dec_hit),
        .op_reg   (rf_rd_data),
        .op_imm   (dec_imm),
        .in_dst   (dec_dst),
        .s1_valid (s1_valid),
        .s1_rec   (s1_rec)
    );

    fmuli_round_stage u_rnd (
        .clk      (clk),
        .rst_n    (rst_n),
        .s1_valid (s1_valid),
        .s1_rec   (s1_rec),
        .ovf_evt  (ovf_evt),
        .unf_evt  (unf_evt),
        .wb_valid (wb_valid),
        .wb_idx   (wb_idx),
        .wb_data  (wb_data)
    );

    fmuli_flags #(.N_FLAGS(2)) u_flg (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_in   ({unf_evt, ovf_evt}),
        .clr_in   (flag_clr),
        .flag_out (flags)
    );

    assign ovf_flag = flags[0];
    assign unf_flag = flags[1];
endmodule

// File: rtl/fmuli_unit_checker.sv
// Module: fmuli_unit_checker
// Port-level temporal properties of fmuli_unit, attached with bind.
module fmuli_unit_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        issue_valid,
    input logic [9:0]  opc_field,
    input logic [2:0]  dst_field,
    input logic        wb_valid,
    input logic [2:0]  wb_idx,
    input logic [30:0] wb_mag,
    input logic        flag_clr,
    input logic        ovf_flag,
    input logic        unf_flag
);
    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && opc_field == 10'b1110100001) |-> ##2 wb_valid);

    p_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_valid && opc_field == 10'b1110100001) |-> ##2 !wb_valid);

    p_dest_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> wb_idx == $past(dst_field, 2));

    p_saturate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> (wb_valid && wb_mag == 31'h7F800000));

    p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unf_flag) |-> (wb_valid && wb_mag == 31'h0));

    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !flag_clr) |=> ovf_flag);

    p_unf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_flag && !flag_clr) |=> unf_flag);

    p_no_nan_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> !(wb_mag[30:23] == 8'hFF && wb_mag[22:0] != 23'h0));

    p_reset_r10: assert property (@(posedge clk)
        !rst_n |=> (!wb_valid && !ovf_flag && !unf_flag));
endmodule

bind fmuli_unit fmuli_unit_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .opc_field   (issue_word[15:6]),
    .dst_field   (issue_word[18:16]),
    .wb_valid    (wb_valid),
    .wb_idx      (wb_idx),
    .wb_mag      (wb_data[30:0]),
    .flag_clr    (flag_clr),
    .ovf_flag    (ovf_flag),
    .unf_flag    (unf_flag)
);

// File: tb/fmuli_unit_bench.sv
`timescale 1ns/1ps
module fmuli_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        issue_valid;
    logic [31:0] issue_word;
    logic [2:0]  rf_rd_idx;
    logic [31:0] rf_rd_data;
    logic        wb_valid;
    logic [2:0]  wb_idx;
    logic [31:0] wb_data;
    logic        flag_clr;
    logic        ovf_flag;
    logic        unf_flag;

    logic [31:0] regs [8];
    assign rf_rd_data = regs[rf_rd_idx];

    always #2.5 clk = ~clk;

    fmuli_unit u_fmuli_unit (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_word(issue_word),
        .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data), .wb_valid(wb_valid),
        .wb_idx(wb_idx), .wb_data(wb_data), .flag_clr(flag_clr),
        .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    typedef struct {
        bit        v;
        bit [2:0]  idx;
        bit [31:0] data;
        bit        ovf;
        bit        unf;
        string     tag;
    } wb_t;

    int  total = 0;
    int  bad = 0;
    bit  done = 0;
    wb_t st0, st1;
    bit  m_ovf = 0, m_unf = 0, clr_prev = 0;

    function automatic wb_t none_entry();
        wb_t e;
        e.v = 0; e.idx = 0; e.data = 0; e.ovf = 0; e.unf = 0; e.tag = "R5";
        return e;
    endfunction

    // instruction encoder: high half {imm[9:0], src, dst}, low half {opcode, imm[15:10]}
    function automatic bit [31:0] mk(bit [2:0] dst, bit [2:0] src, bit [15:0] imm);
        return {imm[9:0], src, dst, 10'b1110100001, imm[15:10]};
    endfunction

    // behavioural single-precision multiply: {ovf, unf, result}
    function automatic bit [33:0] ref_mul(bit [31:0] a, bit [15:0] imm);
        bit [31:0] b = {imm, 16'h0};
        bit        s = a[31] ^ b[31];
        int        ea = int'(a[30:23]);
        int        eb = int'(b[30:23]);
        longint    p, keep, rem, half;
        int        e, sh;
        if (ea == 0 || eb == 0) return {2'b00, s, 31'd0};
        p  = longint'({1'b1, a[22:0]}) * longint'({1'b1, b[22:0]});
        e  = ea + eb - 127;
        sh = 23;
        if (p >= (64'sd1 <<< 47)) begin sh = 24; e++; end
        keep = p >>> sh;
        rem  = p - (keep <<< sh);
        half = 64'sd1 <<< (sh - 1);
        if (rem > half || (rem == half && (keep % 2) == 1)) keep++;
        if (keep == (64'sd1 <<< 24)) begin keep = keep >>> 1; e++; end
        if (e >= 255) return {2'b10, s, 8'hFF, 23'd0};
        if (e <= 0)   return {2'b01, s, 31'd0};
        return {2'b00, s, e[7:0], keep[22:0]};
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // one clock of the reference model: check, retire, shift, drive
    task automatic step(bit v, bit [31:0] w, bit clr, string tag);
        bit [33:0] r;
        string ft;
        m_ovf = (m_ovf & !clr_prev) | (st1.v & st1.ovf);
        m_unf = (m_unf & !clr_prev) | (st1.v & st1.unf);
        ft = st1.v ? st1.tag : tag;
        chk(wb_valid === st1.v, st1.tag, "wb_valid", 32'(wb_valid), 32'(st1.v));
        if (st1.v) begin
            chk(wb_idx === st1.idx, st1.tag, "wb_idx", 32'(wb_idx), 32'(st1.idx));
            chk(wb_data === st1.data, st1.tag, "wb_data", wb_data, st1.data);
            regs[st1.idx] = st1.data;
        end
        chk(ovf_flag === m_ovf, ft, "ovf_flag", 32'(ovf_flag), 32'(m_ovf));
        chk(unf_flag === m_unf, ft, "unf_flag", 32'(unf_flag), 32'(m_unf));
        st1 = st0;
        issue_valid = v;
        issue_word  = w;
        flag_clr    = clr;
        clr_prev    = clr;
        st0 = none_entry();
        if (v && w[15:6] == 10'b1110100001) begin
            r = ref_mul(regs[w[21:19]], {w[5:0], w[31:22]});
            st0.v = 1; st0.idx = w[18:16]; st0.data = r[31:0];
            st0.ovf = r[33]; st0.unf = r[32]; st0.tag = tag;
        end
        #1;
        if (v) chk(rf_rd_idx === w[21:19], "R2", "rf_rd_idx", 32'(rf_rd_idx), 32'(w[21:19]));
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 32'h0, 0, "R1");
    endtask

    initial begin
        #1000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        st0 = none_entry();
        st1 = none_entry();
        rst_n = 0; issue_valid = 0; issue_word = 0; flag_clr = 0;
        for (int i = 0; i < 8; i++) regs[i] = 32'h0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!wb_valid && !ovf_flag && !unf_flag, "R10", "reset outputs",
                {29'd0, wb_valid, ovf_flag, unf_flag}, 32'd0);
        end
        rst_n = 1;
        step(0, 32'h0, 0, "R10");

        // R4: basic products, including the -1.5 immediate
        regs[0] = 32'h40000000; regs[1] = 32'h40800000;
        step(1, mk(3, 0, 16'h4040), 0, "R4");
        step(1, mk(5, 1, 16'hBFC0), 0, "R4");
        idle(2);
        chk(regs[3] == 32'h40C00000, "R4", "2.0*3.0", regs[3], 32'h40C00000);
        chk(regs[5] == 32'hC0C00000, "R4", "4.0*-1.5", regs[5], 32'hC0C00000);

        // R4: tie to even and round up
        regs[2] = 32'h3F800001; regs[1] = 32'h3FFFFFFF;
        step(1, mk(6, 2, 16'h3FC0), 0, "R4");
        step(1, mk(7, 1, 16'h3FC0), 0, "R4");
        idle(2);
        chk(regs[6] == 32'h3FC00002, "R4", "tie to even", regs[6], 32'h3FC00002);

        // R3: low operand half is zero
        regs[0] = 32'h3F800000;
        step(1, mk(1, 0, 16'h3FAB), 0, "R3");
        idle(2);
        chk(regs[1] == 32'h3FAB0000, "R3", "expanded immediate", regs[1], 32'h3FAB0000);

        // R1: bad opcodes and invalid strobe are ignored
        step(1, 32'h12345678, 0, "R1");
        step(1, mk(2, 0, 16'h4040) ^ 32'h0000_0040, 0, "R1");
        step(0, mk(2, 0, 16'h4040), 0, "R1");
        idle(2);

        // R6: zero and denormal operands
        regs[5] = 32'h00000001; regs[6] = 32'h80000000; regs[0] = 32'h3F800000;
        step(1, mk(2, 5, 16'h4040), 0, "R6");
        step(1, mk(3, 6, 16'h4040), 0, "R6");
        step(1, mk(4, 0, 16'h8000), 0, "R6");
        idle(2);

        // R7 and R9: overflow, then sticky across later work, then clear
        regs[3] = 32'h7F000000; regs[0] = 32'h3F800000;
        step(1, mk(2, 3, 16'h4000), 0, "R7");
        idle(2);
        chk(ovf_flag === 1'b1, "R7", "ovf set", 32'(ovf_flag), 32'd1);
        step(1, mk(4, 0, 16'h4000), 0, "R9");
        idle(3);
        step(0, 32'h0, 1, "R9");
        idle(2);
        chk(ovf_flag === 1'b0, "R9", "ovf cleared", 32'(ovf_flag), 32'd0);

        // R8: underflow to signed zero
        regs[4] = 32'h80800000;
        step(1, mk(2, 4, 16'h3F00), 0, "R8");
        idle(2);
        chk(unf_flag === 1'b1, "R8", "unf set", 32'(unf_flag), 32'd1);

        // R9: clear in the delay slot of an overflowing multiply
        regs[3] = 32'h7F000000;
        step(1, mk(5, 3, 16'h4000), 0, "R9");
        step(0, 32'h0, 1, "R9");
        idle(2);
        chk(ovf_flag === 1'b1 && unf_flag === 1'b0, "R9", "set beats clear",
            {30'd0, ovf_flag, unf_flag}, 32'd2);
        step(0, 32'h0, 1, "R9");
        idle(2);

        // R11: exponent 0xFF treated as ordinary
        regs[7] = 32'h7F800000;
        step(1, mk(4, 7, 16'h3F00), 0, "R11");
        step(1, mk(5, 7, 16'h3F80), 0, "R11");
        idle(2);
        chk(regs[4] == 32'h7F000000, "R11", "inf*0.5", regs[4], 32'h7F000000);
        step(0, 32'h0, 1, "R9");
        idle(2);

        // R5: delay slot sees old value, next slot sees new; burst of eight
        regs[0] = 32'h40000000; regs[1] = 32'h3F800000;
        step(1, mk(1, 0, 16'h4000), 0, "R5");
        step(1, mk(2, 1, 16'h4000), 0, "R5");
        step(1, mk(3, 1, 16'h4000), 0, "R5");
        idle(2);
        chk(regs[2] == 32'h40000000, "R5", "delay slot old value", regs[2], 32'h40000000);
        chk(regs[3] == 32'h41000000, "R5", "after slot new value", regs[3], 32'h41000000);
        for (int i = 0; i < 8; i++) step(1, mk(3'(i), 3'(7 - i), 16'h3FC0), 0, "R5");
        idle(2);

        // random stream over all functions
        for (int i = 0; i < 8; i++) regs[i] = $urandom;
        for (int i = 0; i < 400; i++) begin
            bit [31:0] w;
            w = ($urandom % 16 == 0) ? 32'($urandom)
                                     : mk(3'($urandom), 3'($urandom), 16'($urandom));
            step(($urandom % 4) != 0, w, ($urandom % 12) == 0, "R4");
        end
        idle(3);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule